// File: doc/BRIEF.md
# Adapter Wake-Up and Mode Handshake Detector

This block sits on the adapter side of a host parallel port and decides when the adapter joins the conversation. Several adapters can share one port. Each one stays locked and leaves the status lines quiet until the host sends an unlock sequence while holding the select line. That sequence carries the adapter's own unit number. Bytes are sampled from an already synchronised data bus and counted only when the bus value changes.

After the unlock, the host drops select and raises init, then writes a mode byte. The block latches that byte. When the host raises select again, the block echoes the mode bits back on scattered status pins, so the host can confirm it found the right adapter in the right mode. The control line autofd sets the polarity of the echo. When the host releases the lines, the adapter becomes selected and reports its transfer mode. It stays selected until the deselect line that belongs to that mode is asserted.

The control inputs are active-high logical levels. Any inversion at the connector happens outside this block. The data bus, control lines and status lines are level signals and not transactions, so the block has no valid/ready handshake. There is no back-pressure: every new bus value is seen in the cycle it first appears.

Top module: `adapter_wake`

## Requirements
- R1: After reset the block is locked, `status_o` is 0x00, `selected_o` is 0 and `mode_o` is 0.
- R2: A byte is taken from `pd_i` only in a cycle where `pd_i` differs from its value in the previous cycle, and that previous value is 0x00 after reset. Writing a value equal to the current bus value is therefore not a new byte, which is why a host whose bus already holds 0x62 first writes a different byte such as 0x78.
- R3: The unlock sequence is the four new bytes 0x62, 0x70, `unit_i`, ~`unit_i`, all seen while `sel_i` is high. Bytes seen while `sel_i` is low are ignored, and `sel_i` going low in the middle of the sequence restarts it.
- R4: A byte that does not match the byte expected next restarts the sequence. If that byte is 0x62, it counts as the first byte of a new sequence. A byte that matches the expected unit number is accepted even if it is also 0x62.
- R5: After an unlock, once `sel_i` is low and `init_i` is high, the next new byte is the mode byte, and only its bits 3:0 are kept. If bits 2:0 are 3'b111, the byte is rejected and the block locks. If `sel_i` rises before any mode byte arrives, the block also locks.
- R6: From the cycle after a mode byte is accepted until the block becomes selected, `status_o` bit 7 carries mode bit 3 and `status_o` bits 5:3 carry mode bits 2:0. All other status bits are 0.
- R7: During the handshake the echo is sent as-is while `autofd_i` is high. While `autofd_i` is low, bits 7, 5, 4 and 3 of the echo are inverted (mask 0xB8).
- R8: Once `sel_i` has risen after the mode byte, the block becomes selected when `sel_i` is low again and, for a mode with bit 2 set (EPP), `init_i` is also low. While selected, `selected_o` is 1, `mode_o` gives mode bits 2:0 and `status_o` is 0x00.
- R9: A selected adapter in EPP mode (mode bit 2 set) is released by `init_i` high, and `sel_i` has no effect on it. In any other mode it is released by `sel_i` high, and `init_i` has no effect on it. Once released, it is locked again and needs a new unlock sequence.
- R10: Whenever the block is neither in the handshake nor selected, `status_o` is 0x00 and `mode_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_i | input | 8 | Synchronised parallel data bus |
| sel_i | input | 1 | Select control line, active high |
| init_i | input | 1 | Init control line, active high |
| autofd_i | input | 1 | Autofd control line, sets the echo polarity |
| unit_i | input | 8 | Configured unit number of this adapter |
| status_o | output | 8 | Status lines toward the host |
| selected_o | output | 1 | Adapter is selected and active |
| mode_o | output | 3 | Transfer mode while selected: 0–3 byte modes, 4–6 EPP modes |

## Verification
The bench builds the block with its default key bytes, 0x62 and 0x70, so the sequences it sends are the ones the requirements spell out. Because the unit number is an input and not a parameter, one elaboration can swap units between runs. One of those units equals the first key byte, which reaches the case where a unit match must win over a restart. Mode bytes with bit 3 set, with junk in the upper nibble, and with the rejected code 7 cover every echo bit and both deselect rules.

// File: rtl/wake_pkg.sv
`timescale 1ns/1ps
package wake_pkg;
  localparam int BUS_W    = 8;
  localparam int SEQ_LEN  = 4;
  localparam int STAGE_W  = $clog2(SEQ_LEN);
  localparam int SUB_W    = 3;
  localparam int MBYTE_W  = SUB_W + 1;
  localparam int ECHO_LO  = 3;
  localparam int ECHO_TOP = BUS_W - 1;

  typedef logic [BUS_W-1:0]   bus_t;
  typedef logic [MBYTE_W-1:0] mbyte_t;

  localparam bus_t ECHO_MASK = bus_t'(1 << ECHO_TOP) |
                               bus_t'(((1 << SUB_W) - 1) << ECHO_LO);
  localparam logic [SUB_W-1:0] SUB_BAD = '1;

  typedef enum logic [2:0] {
    HS_LOCKED,
    HS_ARMED,
    HS_MODE,
    HS_PEND,
    HS_ECHO,
    HS_LIVE
  } hs_state_e;
endpackage

// File: rtl/bus_change_det.sv
`timescale 1ns/1ps
module bus_change_det #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_i,
  output logic         evt_o
);
  logic [W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= bus_i;
  end

  assign evt_o = (bus_i != last_q);
endmodule

// File: rtl/unlock_matcher.sv
`timescale 1ns/1ps
module unlock_matcher
  import wake_pkg::*;
#(
  parameter bus_t KEY_FIRST  = 8'h62,
  parameter bus_t KEY_SECOND = 8'h70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic sel_i,
  input  logic evt_i,
  input  bus_t bus_i,
  input  bus_t unit_i,
  output logic hit_o
);
  localparam logic [STAGE_W-1:0] LAST_STAGE = STAGE_W'(SEQ_LEN - 1);

  logic [STAGE_W-1:0] stage_q;
  bus_t               key_tab [SEQ_LEN];
  bus_t               want;
  logic               active;
  logic               match;

  always_comb begin
    key_tab[0] = KEY_FIRST;
    key_tab[1] = KEY_SECOND;
    key_tab[2] = unit_i;
    key_tab[3] = ~unit_i;
  end

  assign want   = key_tab[stage_q];
  assign active = en_i && sel_i;
  assign match  = (bus_i == want);
  assign hit_o  = active && evt_i && match && (stage_q == LAST_STAGE);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      stage_q <= '0;
    end else if (evt_i) begin
      if (match)
        stage_q <= (stage_q == LAST_STAGE) ? '0 : stage_q + 1'b1;
      else if (bus_i == KEY_FIRST)
        stage_q <= STAGE_W'(1);
      else
        stage_q <= '0;
    end
  end
endmodule

// File: rtl/mode_handshake.sv
`timescale 1ns/1ps
module mode_handshake
  import wake_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit_i,
  input  logic      evt_i,
  input  mbyte_t    mbyte_i,
  input  logic      sel_i,
  input  logic      init_i,
  output hs_state_e state_o,
  output mbyte_t    mode_o
);
  hs_state_e st_q, st_d;
  mbyte_t    mode_q;
  logic      load;
  logic      epp;

  assign epp = mode_q[SUB_W-1];

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    case (st_q)
      HS_LOCKED: if (hit_i) st_d = HS_ARMED;
      HS_ARMED:  if (!sel_i && init_i) st_d = HS_MODE;
      HS_MODE: begin
        if (sel_i) begin
          st_d = HS_LOCKED;
        end else if (evt_i) begin
          if (mbyte_i[SUB_W-1:0] == SUB_BAD) begin
            st_d = HS_LOCKED;
          end else begin
            st_d = HS_PEND;
            load = 1'b1;
          end
        end
      end
      HS_PEND:   if (sel_i) st_d = HS_ECHO;
      HS_ECHO:   if (!sel_i && !(epp && init_i)) st_d = HS_LIVE;
      HS_LIVE:   if (epp ? init_i : sel_i) st_d = HS_LOCKED;
      default:   st_d = HS_LOCKED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= HS_LOCKED;
      mode_q <= '0;
    end else begin
      st_q <= st_d;
      if (load) mode_q <= mbyte_i;
    end
  end

  assign state_o = st_q;
  assign mode_o  = mode_q;
endmodule

// File: rtl/echo_encode.sv
`timescale 1ns/1ps
module echo_encode
  import wake_pkg::*;
(
  input  mbyte_t mode_i,
  input  logic   en_i,
  input  logic   autofd_i,
  output bus_t   status_o
);
  bus_t raw;

  for (genvar b = 0; b < BUS_W; b++) begin : g_pin
    if (b == ECHO_TOP) begin : g_top
      assign raw[b] = mode_i[SUB_W];
    end else if (b >= ECHO_LO && b < ECHO_LO + SUB_W) begin : g_sub
      assign raw[b] = mode_i[b-ECHO_LO];
    end else begin : g_zero
      assign raw[b] = 1'b0;
    end
  end

  assign status_o = !en_i    ? '0 :
                    autofd_i ? raw : (raw ^ ECHO_MASK);
endmodule

// File: rtl/adapter_wake.sv
`timescale 1ns/1ps
module adapter_wake
  import wake_pkg::*;
#(
  parameter bus_t KEY_FIRST  = 8'h62,
  parameter bus_t KEY_SECOND = 8'h70
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] pd_i,
  input  logic             sel_i,
  input  logic             init_i,
  input  logic             autofd_i,
  input  logic [BUS_W-1:0] unit_i,
  output logic [BUS_W-1:0] status_o,
  output logic             selected_o,
  output logic [SUB_W-1:0] mode_o
);
  logic      evt;
  logic      hit;
  hs_state_e hs_st;
  mbyte_t    mode_q;
  logic      echo_en;

  bus_change_det #(.W(BUS_W)) u_det (
    .clk   (clk),
    .rst_n (rst_n),
    .bus_i (pd_i),
    .evt_o (evt)
  );

  unlock_matcher #(.KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)) u_match (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (hs_st == HS_LOCKED),
    .sel_i  (sel_i),
    .evt_i  (evt),
    .bus_i  (pd_i),
    .unit_i (unit_i),
    .hit_o  (hit)
  );

  mode_handshake u_hs (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit_i   (hit),
    .evt_i   (evt),
    .mbyte_i (pd_i[MBYTE_W-1:0]),
    .sel_i   (sel_i),
    .init_i  (init_i),
    .state_o (hs_st),
    .mode_o  (mode_q)
  );

  assign echo_en = (hs_st == HS_PEND) || (hs_st == HS_ECHO);

  echo_encode u_echo (
    .mode_i   (mode_q),
    .en_i     (echo_en),
    .autofd_i (autofd_i),
    .status_o (status_o)
  );

  assign selected_o = (hs_st == HS_LIVE);
  assign mode_o     = selected_o ? mode_q[SUB_W-1:0] : '0;
endmodule

// File: rtl/adapter_wake_chk.sv
`timescale 1ns/1ps
module adapter_wake_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_i,
  input logic       init_i,
  input logic [7:0] status_o,
  input logic       selected_o,
  input logic [2:0] mode_o
);
  // R6
  unmasked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o & 8'h47) == 8'h00);

  // R8
  live_status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    selected_o |-> status_o == 8'h00);

  // R8
  enter_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(selected_o) |-> $past(!sel_i));

  // R9
  leave_on_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(selected_o) |-> $past(mode_o[2] ? init_i : sel_i));

  // R9
  mode_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (selected_o && $past(selected_o)) |-> $stable(mode_o));

  // R5
  no_bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o != 3'd7);

  // R10
  idle_mode_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !selected_o |-> mode_o == 3'd0);
endmodule

bind adapter_wake adapter_wake_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_i      (sel_i),
  .init_i     (init_i),
  .status_o   (status_o),
  .selected_o (selected_o),
  .mode_o     (mode_o)
);

// File: tb/test_adapter_wake.sv
`timescale 1ns/1ps
module test_adapter_wake;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pd = 8'h00;
  logic       sel = 1'b0;
  logic       init = 1'b0;
  logic       afd = 1'b0;
  logic [7:0] unit = 8'h05;
  logic [7:0] status;
  logic       selected;
  logic [2:0] mode;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  adapter_wake i_adapter_wake (
    .clk(clk), .rst_n(rst_n), .pd_i(pd), .sel_i(sel), .init_i(init),
    .autofd_i(afd), .unit_i(unit), .status_o(status),
    .selected_o(selected), .mode_o(mode)
  );

  // Behavioural reference: 0 locked, 1 armed, 2 wait mode, 3 pending, 4 echo, 5 live
  int         m_st = 0;
  int         m_got = 0;
  logic [7:0] m_prev = 8'h00;
  logic [3:0] m_mode = 4'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_got = 0; m_prev = 8'h00; m_mode = 4'h0;
    end else begin
      logic [7:0] keys [$];
      bit fresh;
      keys = {8'h62, 8'h70, unit, ~unit};
      fresh = (pd != m_prev);
      case (m_st)
        0: begin
          if (!sel) m_got = 0;
          else if (fresh) begin
            if (pd == keys[m_got]) begin
              if (m_got == 3) begin m_st = 1; m_got = 0; end
              else m_got = m_got + 1;
            end else if (pd == 8'h62) m_got = 1;
            else m_got = 0;
          end
        end
        1: if (!sel && init) m_st = 2;
        2: if (sel) m_st = 0;
           else if (fresh) begin
             if (pd[2:0] == 3'd7) m_st = 0;
             else begin m_mode = pd[3:0]; m_st = 3; end
           end
        3: if (sel) m_st = 4;
        4: if (!sel && !(m_mode[2] && init)) m_st = 5;
        5: if (m_mode[2] ? init : sel) m_st = 0;
        default: m_st = 0;
      endcase
      if (m_st != 0) m_got = 0;
      m_prev = pd;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] e_stat;
      logic [7:0] echo;
      echo = {m_mode[3], 1'b0, m_mode[2:0], 3'b000};
      e_stat = (m_st == 3 || m_st == 4) ? (afd ? echo : echo ^ 8'hB8) : 8'h00;
      chk(status == e_stat, "R7 status vs model", status, e_stat);
      chk(selected == (m_st == 5), "R8 selected vs model", selected, m_st == 5);
      chk(mode == ((m_st == 5) ? m_mode[2:0] : 3'd0), "R10 mode vs model",
          mode, (m_st == 5) ? m_mode[2:0] : 3'd0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic look();
    @(negedge clk);
    #1;
  endtask

  task automatic put(input logic [7:0] b);
    pd = b;
    step(2);
  endtask

  task automatic unlock(input logic [7:0] u);
    sel = 1'b1;
    if (pd == 8'h62) put(8'h78);
    put(8'h62); put(8'h70); put(u); put(~u);
    sel = 1'b0;
    step(1);
  endtask

  task automatic give_mode(input logic [7:0] m);
    init = 1'b1;
    step(1);
    put(m);
  endtask

  task automatic confirm(input logic [7:0] echo, input bit epp, input logic [2:0] em,
                         input string tag);
    sel = 1'b1; afd = 1'b1;
    step(2); look();
    chk(status == echo, {tag, " R6 echo true"}, status, echo);
    afd = 1'b0;
    step(1); look();
    chk(status == (echo ^ 8'hB8), {tag, " R7 echo inverted"}, status, echo ^ 8'hB8);
    sel = 1'b0;
    if (epp) init = 1'b0;
    step(2); look();
    chk(selected == 1'b1, {tag, " R8 selected"}, selected, 1);
    chk(mode == em, {tag, " R8 mode"}, mode, em);
    chk(status == 8'h00, {tag, " R8 status quiet"}, status, 0);
  endtask

  task automatic quiet_probe(input string tag);
    sel = 1'b1; afd = 1'b1;
    step(2); look();
    chk(status == 8'h00, tag, status, 0);
    chk(selected == 1'b0, tag, selected, 0);
    sel = 1'b0; init = 1'b0; afd = 1'b0;
    step(2);
  endtask

  initial begin
    #(20 * 60000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1); look();
    chk(status == 8'h00, "R1 reset status", status, 0);
    chk(selected == 1'b0, "R1 reset selected", selected, 0);
    chk(mode == 3'd0, "R1 reset mode", mode, 0);

    // Byte mode 1, deselect by select line
    unit = 8'h05;
    unlock(unit); give_mode(8'h01);
    confirm(8'h08, 1'b0, 3'd1, "byte1");
    init = 1'b1; step(2); look();
    chk(selected == 1'b1, "R9 init ignored in byte mode", selected, 1);
    sel = 1'b1; step(2); look();
    chk(selected == 1'b0, "R9 select releases byte mode", selected, 0);
    chk(status == 8'h00, "R10 status after release", status, 0);
    sel = 1'b0; init = 1'b0; step(2);

    // EPP with bit 3 set, deselect by init line
    unlock(unit); give_mode(8'h0C);
    confirm(8'hA0, 1'b1, 3'd4, "epp");
    sel = 1'b1; step(2); look();
    chk(selected == 1'b1, "R9 select ignored in EPP", selected, 1);
    sel = 1'b0; init = 1'b1; step(2); look();
    chk(selected == 1'b0, "R9 init releases EPP", selected, 0);
    init = 1'b0; step(2);

    // Upper nibble ignored, EPP dword code
    unlock(unit); give_mode(8'hF6);
    confirm(8'h30, 1'b1, 3'd6, "dword R5");
    init = 1'b1; step(2); init = 1'b0; step(2);

    // Rejected mode code
    unlock(unit); give_mode(8'h07);
    quiet_probe("R5 code 7 rejected");

    // Sequence without select
    sel = 1'b0;
    put(8'h62); put(8'h70); put(unit); put(~unit);
    give_mode(8'h01);
    quiet_probe("R3 no select ignored");

    // Wrong unit
    unlock(8'h06); give_mode(8'h01);
    quiet_probe("R3 wrong unit");

    // Select dropped mid-sequence
    sel = 1'b1; put(8'h62); put(8'h70);
    sel = 1'b0; step(2);
    sel = 1'b1; put(unit); put(~unit);
    sel = 1'b0; step(1); give_mode(8'h01);
    quiet_probe("R3 select drop restarts");

    // Mismatch equal to first key restarts as first byte
    sel = 1'b1;
    put(8'h62); put(8'h70); put(8'h62); put(8'h70); put(unit); put(~unit);
    sel = 1'b0; step(1); give_mode(8'h03);
    confirm(8'h18, 1'b0, 3'd3, "R4 restart");
    sel = 1'b1; step(2); sel = 1'b0; init = 1'b0; step(2);

    // Bus already holds first key: repeated value is not a byte
    pd = 8'h62; step(2);
    sel = 1'b1; put(8'h62); put(8'h70); put(unit); put(~unit);
    sel = 1'b0; step(1); give_mode(8'h01);
    quiet_probe("R2 repeated value unseen");
    pd = 8'h62; step(2);
    unlock(unit); give_mode(8'h02);
    confirm(8'h10, 1'b0, 3'd2, "R2 after 0x78");
    sel = 1'b1; step(2); sel = 1'b0; init = 1'b0; step(2);

    // Unit equal to first key: unit match wins
    unit = 8'h62;
    unlock(unit); give_mode(8'h05);
    confirm(8'h28, 1'b1, 3'd5, "R4 unit priority");
    init = 1'b1; step(2); look();
    chk(selected == 1'b0, "R9 EPP word released", selected, 0);
    init = 1'b0; step(2);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule